// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator with Deferred Update

This block produces one pulse-width-modulated output from a free-running phase accumulator. On every clock the accumulator adds an active 16-bit increment, so the output frequency is the clock frequency times the increment divided by 65536. The upper eight bits of the accumulator are compared with an active 8-bit threshold. The threshold works inverted: a threshold near 255 gives a short high time, and a threshold of 0 keeps the output high for the whole period.

Software controls the block through a single 32-bit control word on a simple synchronous write port. A combinational read port returns the same word. A write lands in staged copies of the increment and threshold. The staged values reach the active copies only when an update has been requested and a period boundary arrives. A period boundary is either the clock on which the accumulator wraps past its top, or any clock on which the accumulator sits at zero, which is always the case while the block is disabled. Because of this, a new setting never cuts a running period short.

Top module: `phase_pwm`

## Requirements
- R1: After reset the read word is all zeros and `pwm_out` is low. The active increment and the active threshold are also zero.
- R2: The read word holds the enable flag at bit 31 and the pending-update flag at bit 30. Bits 29:24 read as zero, bits 23:8 hold the staged increment and bits 7:0 hold the staged threshold. A write loads the enable flag, the staged increment and the staged threshold from the same bit positions, and bit 30 of the write sets or clears the pending flag.
- R3: While enabled, the accumulator adds the active increment modulo 65536 on every clock. With an increment of 0x0100 the output period is exactly 256 clocks, and with 0x8000 it is 2 clocks.
- R4: `pwm_out` is high exactly when the block is enabled and accumulator bits 15:8 are greater than or equal to the active threshold.
- R5: A write whose bit 30 is clear changes only the staged values and the enable flag. The active increment and threshold, and so the waveform, stay unchanged.
- R6: When the pending flag is set, the staged increment and threshold are copied to the active ones on the next clock on which the accumulator wraps past 0xFFFF or holds zero. The pending flag clears on that same clock unless a write sets it again.
- R7: While the enable flag is clear, `pwm_out` is low and the accumulator is held at zero. A pending update is therefore applied on the next clock.
- R8: Setting the enable flag again restarts the waveform from accumulator zero with the active settings, whatever staged values exist.
- R9: When a write with bit 30 set lands on the same clock as an update being applied, the update uses the staged values from before that write. The pending flag stays set, so the new values are applied at the following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the accumulator advances on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Write strobe for the control word, sampled on the rising edge |
| reg_wdata | input | 32 | Control word to write |
| reg_rdata | output | 32 | Current control word (live enable flag, pending flag, staged fields) |
| pwm_out | output | 1 | PWM waveform |

## Verification
Whatever is written on a rising edge appears in `reg_rdata` straight after that edge. An update requested on that edge reaches the active settings no sooner than the next edge at a boundary. The output follows the registered accumulator through a compare with no further register, so its value for a given clock is valid right after that clock's edge. The bench applies each input half a cycle before an edge. It advances its own cycle model at that edge and compares both outputs at the following falling edge. Directed runs count high cycles over whole numbers of periods, which makes those checks independent of the phase.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;
  // control word geometry
  localparam int unsigned CTRL_W  = 32;
  localparam int unsigned ACC_W   = 16;
  localparam int unsigned THR_W   = 8;
  localparam int unsigned EN_BIT  = 31;
  localparam int unsigned UPD_BIT = 30;
  localparam int unsigned INC_LSB = 8;
  localparam int unsigned THR_LSB = 0;
  // derived positions
  localparam int unsigned INC_MSB = INC_LSB + ACC_W - 1;
  localparam int unsigned THR_MSB = THR_LSB + THR_W - 1;
  localparam int unsigned CMP_LSB = ACC_W - THR_W;
  localparam int unsigned GAP_W   = UPD_BIT - INC_MSB - 1;

  typedef struct packed {
    logic [ACC_W-1:0] inc;
    logic [THR_W-1:0] thr;
  } pwm_cfg_t;
endpackage

// File: rtl/phase_pwm_rstsync.sv
module phase_pwm_rstsync #(
  parameter int unsigned STAGES = 2   // at least 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/phase_pwm_regs.sv
module phase_pwm_regs
  import phase_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              apply_i,
  output logic              en_o,
  output logic              pend_o,
  output pwm_cfg_t          stg_o,
  output logic [CTRL_W-1:0] rdata_o
);
  logic     en_q,  en_d;
  logic     pend_q, pend_d;
  pwm_cfg_t stg_q, stg_d;
  logic     stg_ce;

  // next state
  always_comb begin
    en_d   = en_q;
    stg_d  = stg_q;
    stg_ce = we_i;
    if (we_i) begin
      en_d      = wdata_i[EN_BIT];
      stg_d.inc = wdata_i[INC_MSB:INC_LSB];
      stg_d.thr = wdata_i[THR_MSB:THR_LSB];
    end
    // a fresh request always wins over the clear from an update in flight
    if (we_i)         pend_d = wdata_i[UPD_BIT];
    else if (apply_i) pend_d = 1'b0;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stg_q <= '0;
    else if (stg_ce) stg_q <= stg_d;
  end

  assign en_o    = en_q;
  assign pend_o  = pend_q;
  assign stg_o   = stg_q;
  assign rdata_o = {en_q, pend_q, {GAP_W{1'b0}}, stg_q.inc, stg_q.thr};

  AST_PEND_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(apply_i || we_i)); // R6

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ($stable(stg_q) && $stable(en_q))); // R5
endmodule

// File: rtl/phase_pwm_core.sv
module phase_pwm_core
  import phase_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_i,
  input  logic     pend_i,
  input  pwm_cfg_t stg_i,
  output logic     apply_o,
  output logic     pwm_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;
  logic             wrap;
  logic             at_zero;
  pwm_cfg_t         act_q;
  logic             act_ce;

  // accumulator next state and period boundary detection
  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, act_q.inc};
    wrap    = en_i & sum[ACC_W];
    at_zero = (acc_q == '0);
    acc_d   = en_i ? sum[ACC_W-1:0] : '0;
    act_ce  = pend_i & (wrap | at_zero);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (act_ce) act_q <= stg_i;
  end

  assign apply_o = act_ce;
  assign pwm_o   = en_i & (acc_q[ACC_W-1:CMP_LSB] >= act_q.thr);

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (acc_q == ACC_W'($past(acc_q) + $past(act_q.inc)))); // R3

  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (acc_q == '0)); // R7

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_o |=> $stable(act_q)); // R6
endmodule

// File: rtl/phase_pwm.sv
module phase_pwm
  import phase_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic              pwm_out
);
  logic     rst_sync_n;
  logic     en, pend, apply;
  pwm_cfg_t stg;

  phase_pwm_rstsync #(.STAGES(2)) i_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  phase_pwm_regs i_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (reg_we),
    .wdata_i (reg_wdata),
    .apply_i (apply),
    .en_o    (en),
    .pend_o  (pend),
    .stg_o   (stg),
    .rdata_o (reg_rdata)
  );

  phase_pwm_core i_core (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_i    (en),
    .pend_i  (pend),
    .stg_i   (stg),
    .apply_o (apply),
    .pwm_o   (pwm_out)
  );

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_we && !reg_wdata[EN_BIT]) |=> !pwm_out); // R7
endmodule

// File: tb/test_phase_pwm.sv
`timescale 1ns/100ps
module test_phase_pwm;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  always #2.5 clk = ~clk;

  phase_pwm i_phase_pwm (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out)
  );

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  int unsigned hi_cnt = 0;
  bit          done = 1'b0;

  // reference state, built from the requirements
  bit        m_en, m_pend;
  bit [15:0] m_acc, m_act_inc, m_stg_inc;
  bit [7:0]  m_act_thr, m_stg_thr;

  function automatic bit [31:0] word(bit en, bit upd, bit [15:0] inc, bit [7:0] thr);
    return {en, upd, 6'b0, inc, thr};
  endfunction

  function automatic bit exp_pwm();
    return m_en && (m_acc[15:8] >= m_act_thr);           // R4
  endfunction

  function automatic bit [31:0] exp_rd();
    return {m_en, m_pend, 6'b0, m_stg_inc, m_stg_thr};   // R2
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(input bit we, input bit [31:0] d);
    bit [16:0] sum;
    bit        wrap, apply;
    sum   = {1'b0, m_acc} + {1'b0, m_act_inc};
    wrap  = m_en && sum[16];                              // R3
    apply = m_pend && (wrap || m_acc == 16'h0);           // R6
    m_acc = m_en ? sum[15:0] : 16'h0;                     // R7
    if (apply) begin
      m_act_inc = m_stg_inc;
      m_act_thr = m_stg_thr;
    end
    if (we) begin
      m_pend    = d[30];                                  // R9
      m_en      = d[31];
      m_stg_inc = d[23:8];
      m_stg_thr = d[7:0];
    end else if (apply) begin
      m_pend = 1'b0;
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit we, input bit [31:0] d);
    reg_we    = we;
    reg_wdata = d;
    @(posedge clk);
    model_edge(we, d);
    @(negedge clk);
    reg_we = 1'b0;
    chk("R4 pwm_out", {31'b0, pwm_out}, {31'b0, exp_pwm()});
    chk("R2 reg_rdata", reg_rdata, exp_rd());
    if (pwm_out) hi_cnt++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 32'h0);
  endtask

  initial begin
    int unsigned r;
    rst_n     = 1'b0;
    reg_we    = 1'b0;
    reg_wdata = 32'h0;
    {m_en, m_pend, m_acc, m_act_inc, m_stg_inc, m_act_thr, m_stg_thr} = '0;
    r = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk("R1 rdata in reset", reg_rdata, 32'h0);
    chk("R1 pwm in reset", {31'b0, pwm_out}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rdata after reset", reg_rdata, 32'h0);
    chk("R1 pwm after reset", {31'b0, pwm_out}, 32'h0);

    // R7: update requested while disabled is applied on the next clock
    step(1'b1, word(1'b0, 1'b1, 16'h0100, 8'h80));
    chk("R7 pending set", {31'b0, reg_rdata[30]}, 32'h1);
    step(1'b0, 32'h0);
    chk("R7 pending cleared while disabled", {31'b0, reg_rdata[30]}, 32'h0);
    chk("R7 output low while disabled", {31'b0, pwm_out}, 32'h0);

    // R8 and R3: enable with active settings, 256-clock period, half duty
    step(1'b1, word(1'b1, 1'b0, 16'h0100, 8'h80));
    hi_cnt = 0;
    idle(512);
    chk("R3 high count inc=0x100 thr=0x80", hi_cnt, 32'd256);

    // R5: staged change without request leaves waveform alone
    step(1'b1, word(1'b1, 1'b0, 16'h0200, 8'h10));
    chk("R2 staged fields readback", reg_rdata, 32'h8002_0010);
    hi_cnt = 0;
    idle(512);
    chk("R5 waveform unchanged", hi_cnt, 32'd256);

    // R6: request lands at a wrap
    step(1'b1, word(1'b1, 1'b1, 16'h0200, 8'h10));
    idle(300);
    chk("R6 pending cleared at boundary", {31'b0, reg_rdata[30]}, 32'h0);
    hi_cnt = 0;
    idle(512);
    chk("R6 high count inc=0x200 thr=0x10", hi_cnt, 32'd480);

    // R9: write landing on the apply clock keeps the request pending
    step(1'b1, word(1'b0, 1'b0, 16'h0200, 8'h10));
    step(1'b1, word(1'b0, 1'b1, 16'h0100, 8'h00));
    step(1'b1, word(1'b0, 1'b1, 16'h8000, 8'hFF));
    chk("R9 pending survives apply", {31'b0, reg_rdata[30]}, 32'h1);
    step(1'b0, 32'h0);
    step(1'b1, word(1'b1, 1'b0, 16'h8000, 8'hFF));
    hi_cnt = 0;
    idle(64);
    chk("R9 later values applied (never high)", hi_cnt, 32'd0);

    // R3: half-scale increment, 2-clock period
    step(1'b1, word(1'b1, 1'b1, 16'h8000, 8'h80));
    idle(8);
    hi_cnt = 0;
    idle(64);
    chk("R3 high count inc=0x8000 thr=0x80", hi_cnt, 32'd32);

    // random mix
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 39) == 0) begin
        bit [15:0] inc;
        inc = 16'($urandom_range(0, 32768));
        step(1'b1, word($urandom_range(0, 7) != 0, 1'($urandom_range(0, 1)),
                        inc, 8'($urandom_range(0, 255))));
      end else begin
        step(1'b0, 32'h0);
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule